// File: doc/BRIEF.md
# Vector Operand Transfer Unit

This unit sits between a SIMD datapath and its vector register file and moves operand values in both directions. On the source side, a selector either names a vector register or asks for a broadcast value. A vector source is read across every lane from one register, or from two consecutive registers for 64-bit formats. A broadcast source copies the supplied scalar value onto all lanes. The unit then trims the value to the width of the operand format. For floating-point formats it can also apply an absolute-value modifier, a negate modifier, or both. The result is registered and arrives one cycle after the request.

On the destination side, a per-lane result is split into a low register word and, for 64-bit formats, a high word that goes to the next register. The unit produces one write enable per lane for each of the two registers. An enable is raised when the lane's bit in the execution mask is set. The instruction can bypass the mask with an ignore flag. Load instructions use the mask they captured at issue instead of the wavefront's live mask. Register indices are offset by the wavefront's register base before they reach the file. The register storage, the resolution of broadcast values and the arithmetic itself lie outside this unit.

Top module: `vop_xfer`

## Requirements
- R1: A source request whose selector bit 8 is 1 reads register `wave_vbase + sel[7:0]`. `src_valid` rises exactly one cycle after `src_req`, and lane l of `src_data` then carries that register's lane l word. The 32-bit formats are U32 (code 1) and F32 (code 4); for these, bits 63:32 of the lane read zero.
- R2: For 64-bit formats, U64 (code 2) and F64 (code 5), the addressed register supplies bits 31:0 of each lane and the next register supplies bits 63:32. The second read port is enabled only for these formats.
- R3: When selector bit 8 is 0, `scalar_val`, trimmed to the format width, appears identically on every lane.
- R4: For 16-bit formats, U16 (code 0) and F16 (code 3), only bits 15:0 are used. On reads the upper lane bits are zero. On writes the low register word receives `{16'b0, data[15:0]}`.
- R5: For floating-point formats (codes 3, 4, 5), the sign bit sits at bit 15, 31 or 63. The absolute-value modifier clears that sign bit. The negate modifier inverts it. When both are set, the clear happens first and the inversion second, so the result is always negative.
- R6: For integer formats (codes 0, 1, 2), both modifiers have no effect on the data.
- R7: On a destination request, the write enable of lane l is raised one cycle later if bit l of `wave_exec` is set, or for every lane if `dst_ignore_exec` is set. Lanes that are not enabled keep their register contents.
- R8: When `dst_is_load` is set, `dst_load_mask` replaces `wave_exec` in the lane enable of R7.
- R9: A write sends bits 31:0 of each lane to register `wave_vbase + dst_idx`. For 64-bit formats it also sends bits 63:32 to the next register, under the same lane enables. For other formats the high enables stay low.
- R10: While reset is high and in the first cycle after it, `src_valid` and all write enables are low.
- R11: All register addresses are computed modulo 256, so a base plus an index, and the +1 for the high word, wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 1 | Source operand read request |
| src_sel | input | 9 | Bit 8: vector register; bits 7:0: register index |
| src_fmt | input | 3 | Source operand format code |
| src_abs | input | 1 | Absolute-value modifier |
| src_neg | input | 1 | Negate modifier |
| scalar_val | input | 64 | Broadcast value for non-vector selectors |
| wave_vbase | input | 8 | Wavefront register base |
| rf_rd_en0 | output | 1 | Read enable, low word register |
| rf_rd_en1 | output | 1 | Read enable, high word register |
| rf_rd_addr0 | output | 8 | Read address, low word |
| rf_rd_addr1 | output | 8 | Read address, high word |
| rf_rd_data0 | input | LANES*32 | Low word read data, all lanes |
| rf_rd_data1 | input | LANES*32 | High word read data, all lanes |
| src_valid | output | 1 | Source data valid |
| src_data | output | LANES*64 | Per-lane source values |
| dst_req | input | 1 | Destination writeback request |
| dst_idx | input | 8 | Destination register index |
| dst_fmt | input | 3 | Destination format code |
| dst_data | input | LANES*64 | Per-lane results |
| dst_is_load | input | 1 | Writeback belongs to a load |
| dst_load_mask | input | LANES | Mask captured by the load |
| wave_exec | input | LANES | Wavefront execution mask |
| dst_ignore_exec | input | 1 | Write all lanes regardless of mask |
| rf_wr_en0 | output | LANES | Per-lane write enable, low word |
| rf_wr_en1 | output | LANES | Per-lane write enable, high word |
| rf_wr_addr0 | output | 8 | Write address, low word |
| rf_wr_addr1 | output | 8 | Write address, high word |
| rf_wr_data0 | output | LANES*32 | Write data, low words |
| rf_wr_data1 | output | LANES*32 | Write data, high words |

## Verification
The unit holds only one stage of registered state per side. A wrong captured value therefore shows up at the ports in the very next cycle: as a wrong lane word in `src_data`, or as a wrong enable bit or address on the write side. There is nothing deeper for it to hide in. Mask selection errors are the subtle case, because a wrongly cleared enable leaves the stale register word in place. The bench therefore reads back written registers and checks that masked lanes still hold their earlier contents. Modifier ordering and sign-bit placement are exercised on values whose sign bit is both set and clear in every floating-point width.

// File: rtl/vop_pkg.sv
`timescale 1ns/1ps
package vop_pkg;

    localparam int WORD_W = 32;
    localparam int LVAL_W = 2 * WORD_W;

    typedef enum logic [2:0] {
        FMT_U16 = 3'd0,
        FMT_U32 = 3'd1,
        FMT_U64 = 3'd2,
        FMT_F16 = 3'd3,
        FMT_F32 = 3'd4,
        FMT_F64 = 3'd5
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic is_vec;
        logic abs_m;
        logic neg_m;
    } src_mod_t;

    function automatic logic fmt_wide(fmt_e f);
        return (f == FMT_U64) || (f == FMT_F64);
    endfunction

    function automatic logic fmt_half(fmt_e f);
        return (f == FMT_U16) || (f == FMT_F16);
    endfunction

    // Trim a lane value to the width of its format, zero above.
    function automatic logic [LVAL_W-1:0] fit_width(fmt_e f, logic [LVAL_W-1:0] v);
        logic [LVAL_W-1:0] r;
        if (fmt_half(f))
            r = {{(LVAL_W-16){1'b0}}, v[15:0]};
        else if (fmt_wide(f))
            r = v;
        else
            r = {{(LVAL_W-WORD_W){1'b0}}, v[WORD_W-1:0]};
        return r;
    endfunction

    // One-hot sign position for floating formats, zero for integers.
    function automatic logic [LVAL_W-1:0] sign_bit(fmt_e f);
        logic [LVAL_W-1:0] m;
        m = '0;
        case (f)
            FMT_F16: m[15]         = 1'b1;
            FMT_F32: m[WORD_W-1]   = 1'b1;
            FMT_F64: m[LVAL_W-1]   = 1'b1;
            default: m             = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vop_src_lane.sv
`timescale 1ns/1ps
module vop_src_lane
    import vop_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [LVAL_W-1:0] bcast,
    input  src_mod_t          mods,
    output logic [LVAL_W-1:0] lane_val
);

    logic [LVAL_W-1:0] raw;
    logic [LVAL_W-1:0] trimmed;
    logic [LVAL_W-1:0] smask;
    logic [LVAL_W-1:0] after_abs;

    always_comb begin
        raw       = mods.is_vec ? {hi_word, lo_word} : bcast;
        trimmed   = fit_width(mods.fmt, raw);
        smask     = sign_bit(mods.fmt);
        // absolute value first, then negation
        after_abs = mods.abs_m ? (trimmed & ~smask) : trimmed;
        lane_val  = mods.neg_m ? (after_abs ^ smask) : after_abs;
    end

endmodule

// File: rtl/vop_src_path.sv
`timescale 1ns/1ps
module vop_src_path
    import vop_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int REG_AW = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      src_req,
    input  logic [REG_AW:0]           src_sel,
    input  logic [2:0]                src_fmt,
    input  logic                      src_abs,
    input  logic                      src_neg,
    input  logic [LVAL_W-1:0]         scalar_val,
    input  logic [REG_AW-1:0]         wave_vbase,
    output logic                      rd_en0,
    output logic                      rd_en1,
    output logic [REG_AW-1:0]         rd_addr0,
    output logic [REG_AW-1:0]         rd_addr1,
    input  logic [LANES*WORD_W-1:0]   rd_data0,
    input  logic [LANES*WORD_W-1:0]   rd_data1,
    output logic                      src_valid,
    output logic [LANES*LVAL_W-1:0]   src_data
);

    localparam int SEL_VEC_BIT = REG_AW;

    src_mod_t                  mods;
    logic [LANES*LVAL_W-1:0]   lane_vals;

    always_comb begin
        mods.fmt    = fmt_e'(src_fmt);
        mods.is_vec = src_sel[SEL_VEC_BIT];
        mods.abs_m  = src_abs;
        mods.neg_m  = src_neg;
    end

    assign rd_addr0 = wave_vbase + src_sel[REG_AW-1:0];
    assign rd_addr1 = rd_addr0 + REG_AW'(1);
    assign rd_en0   = src_req & mods.is_vec;
    assign rd_en1   = src_req & mods.is_vec & fmt_wide(mods.fmt);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vop_src_lane u_lane (
            .lo_word  (rd_data0[l*WORD_W +: WORD_W]),
            .hi_word  (rd_data1[l*WORD_W +: WORD_W]),
            .bcast    (scalar_val),
            .mods     (mods),
            .lane_val (lane_vals[l*LVAL_W +: LVAL_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_valid <= 1'b0;
            src_data  <= '0;
        end else begin
            src_valid <= src_req;
            if (src_req)
                src_data <= lane_vals;
        end
    end

endmodule

// File: rtl/vop_dst_path.sv
`timescale 1ns/1ps
module vop_dst_path
    import vop_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int REG_AW = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dst_req,
    input  logic [REG_AW-1:0]         dst_idx,
    input  logic [2:0]                dst_fmt,
    input  logic [LANES*LVAL_W-1:0]   dst_data,
    input  logic                      dst_is_load,
    input  logic [LANES-1:0]          dst_load_mask,
    input  logic [LANES-1:0]          wave_exec,
    input  logic                      dst_ignore_exec,
    input  logic [REG_AW-1:0]         wave_vbase,
    output logic [LANES-1:0]          wr_en0,
    output logic [LANES-1:0]          wr_en1,
    output logic [REG_AW-1:0]         wr_addr0,
    output logic [REG_AW-1:0]         wr_addr1,
    output logic [LANES*WORD_W-1:0]   wr_data0,
    output logic [LANES*WORD_W-1:0]   wr_data1
);

    fmt_e                      fmt;
    logic                      wide;
    logic [LANES-1:0]          eff_mask;
    logic [LANES-1:0]          en0_d;
    logic [LANES-1:0]          en1_d;
    logic [LANES*WORD_W-1:0]   lo_d;
    logic [LANES*WORD_W-1:0]   hi_d;
    logic [REG_AW-1:0]         base_addr;

    assign fmt       = fmt_e'(dst_fmt);
    assign wide      = fmt_wide(fmt);
    assign eff_mask  = dst_is_load ? dst_load_mask : wave_exec;
    assign base_addr = wave_vbase + dst_idx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LVAL_W-1:0] fitted;
        assign fitted = fit_width(fmt, dst_data[l*LVAL_W +: LVAL_W]);
        assign en0_d[l] = dst_req & (dst_ignore_exec | eff_mask[l]);
        assign en1_d[l] = en0_d[l] & wide;
        assign lo_d[l*WORD_W +: WORD_W] = fitted[WORD_W-1:0];
        assign hi_d[l*WORD_W +: WORD_W] = fitted[LVAL_W-1:WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en0   <= '0;
            wr_en1   <= '0;
            wr_addr0 <= '0;
            wr_addr1 <= '0;
            wr_data0 <= '0;
            wr_data1 <= '0;
        end else begin
            wr_en0 <= en0_d;
            wr_en1 <= en1_d;
            if (dst_req) begin
                wr_addr0 <= base_addr;
                wr_addr1 <= base_addr + REG_AW'(1);
                wr_data0 <= lo_d;
                wr_data1 <= hi_d;
            end
        end
    end

endmodule

// File: rtl/vop_xfer.sv
`timescale 1ns/1ps
module vop_xfer
    import vop_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int REG_AW = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      src_req,
    input  logic [REG_AW:0]           src_sel,
    input  logic [2:0]                src_fmt,
    input  logic                      src_abs,
    input  logic                      src_neg,
    input  logic [63:0]               scalar_val,
    input  logic [REG_AW-1:0]         wave_vbase,
    output logic                      rf_rd_en0,
    output logic                      rf_rd_en1,
    output logic [REG_AW-1:0]         rf_rd_addr0,
    output logic [REG_AW-1:0]         rf_rd_addr1,
    input  logic [LANES*32-1:0]       rf_rd_data0,
    input  logic [LANES*32-1:0]       rf_rd_data1,
    output logic                      src_valid,
    output logic [LANES*64-1:0]       src_data,
    input  logic                      dst_req,
    input  logic [REG_AW-1:0]         dst_idx,
    input  logic [2:0]                dst_fmt,
    input  logic [LANES*64-1:0]       dst_data,
    input  logic                      dst_is_load,
    input  logic [LANES-1:0]          dst_load_mask,
    input  logic [LANES-1:0]          wave_exec,
    input  logic                      dst_ignore_exec,
    output logic [LANES-1:0]          rf_wr_en0,
    output logic [LANES-1:0]          rf_wr_en1,
    output logic [REG_AW-1:0]         rf_wr_addr0,
    output logic [REG_AW-1:0]         rf_wr_addr1,
    output logic [LANES*32-1:0]       rf_wr_data0,
    output logic [LANES*32-1:0]       rf_wr_data1
);

    vop_src_path #(.LANES(LANES), .REG_AW(REG_AW)) u_src (
        .clk        (clk),
        .rst        (rst),
        .src_req    (src_req),
        .src_sel    (src_sel),
        .src_fmt    (src_fmt),
        .src_abs    (src_abs),
        .src_neg    (src_neg),
        .scalar_val (scalar_val),
        .wave_vbase (wave_vbase),
        .rd_en0     (rf_rd_en0),
        .rd_en1     (rf_rd_en1),
        .rd_addr0   (rf_rd_addr0),
        .rd_addr1   (rf_rd_addr1),
        .rd_data0   (rf_rd_data0),
        .rd_data1   (rf_rd_data1),
        .src_valid  (src_valid),
        .src_data   (src_data)
    );

    vop_dst_path #(.LANES(LANES), .REG_AW(REG_AW)) u_dst (
        .clk             (clk),
        .rst             (rst),
        .dst_req         (dst_req),
        .dst_idx         (dst_idx),
        .dst_fmt         (dst_fmt),
        .dst_data        (dst_data),
        .dst_is_load     (dst_is_load),
        .dst_load_mask   (dst_load_mask),
        .wave_exec       (wave_exec),
        .dst_ignore_exec (dst_ignore_exec),
        .wave_vbase      (wave_vbase),
        .wr_en0          (rf_wr_en0),
        .wr_en1          (rf_wr_en1),
        .wr_addr0        (rf_wr_addr0),
        .wr_addr1        (rf_wr_addr1),
        .wr_data0        (rf_wr_data0),
        .wr_data1        (rf_wr_data1)
    );

endmodule

// File: rtl/vop_xfer_chk.sv
`timescale 1ns/1ps
module vop_xfer_chk #(
    parameter int LANES  = 64,
    parameter int REG_AW = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   src_req,
    input logic [REG_AW:0]        src_sel,
    input logic                   src_valid,
    input logic [LANES*64-1:0]    src_data,
    input logic                   rf_rd_en0,
    input logic                   rf_rd_en1,
    input logic                   dst_req,
    input logic                   dst_ignore_exec,
    input logic [LANES-1:0]       rf_wr_en0,
    input logic [LANES-1:0]       rf_wr_en1,
    input logic [REG_AW-1:0]      rf_wr_addr0,
    input logic [REG_AW-1:0]      rf_wr_addr1
);

    logic bcast_uniform;

    always_comb begin
        bcast_uniform = 1'b1;
        for (int l = 1; l < LANES; l++)
            if (src_data[l*64 +: 64] != src_data[63:0])
                bcast_uniform = 1'b0;
    end

    // R1
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        src_req |=> src_valid);

    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !src_req |=> !src_valid);

    // R2
    hi_read_needs_lo_chk: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en1 |-> rf_rd_en0);

    // R3
    bcast_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (src_req && !src_sel[REG_AW]) |=> bcast_uniform);

    // R7
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !dst_req |=> (rf_wr_en0 == '0));

    // R7
    ignore_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_req && dst_ignore_exec) |=> (&rf_wr_en0));

    // R9
    hi_write_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en1 & ~rf_wr_en0) == '0);

    // R11
    hi_write_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (|rf_wr_en1) |-> (rf_wr_addr1 == REG_AW'(rf_wr_addr0 + REG_AW'(1))));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!src_valid && rf_wr_en0 == '0 && rf_wr_en1 == '0));

endmodule

bind vop_xfer vop_xfer_chk #(.LANES(LANES), .REG_AW(REG_AW)) u_vop_xfer_chk (
    .clk             (clk),
    .rst             (rst),
    .src_req         (src_req),
    .src_sel         (src_sel),
    .src_valid       (src_valid),
    .src_data        (src_data),
    .rf_rd_en0       (rf_rd_en0),
    .rf_rd_en1       (rf_rd_en1),
    .dst_req         (dst_req),
    .dst_ignore_exec (dst_ignore_exec),
    .rf_wr_en0       (rf_wr_en0),
    .rf_wr_en1       (rf_wr_en1),
    .rf_wr_addr0     (rf_wr_addr0),
    .rf_wr_addr1     (rf_wr_addr1)
);

// File: tb/tb_vop_xfer.sv
`timescale 1ns/1ps
module tb_vop_xfer;

    localparam int LANES  = 64;
    localparam int REG_AW = 8;
    localparam int NREG   = 256;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst;
    logic                  src_req;
    logic [REG_AW:0]       src_sel;
    logic [2:0]            src_fmt;
    logic                  src_abs, src_neg;
    logic [63:0]           scalar_val;
    logic [REG_AW-1:0]     wave_vbase;
    logic                  rf_rd_en0, rf_rd_en1;
    logic [REG_AW-1:0]     rf_rd_addr0, rf_rd_addr1;
    logic [LANES*32-1:0]   rf_rd_data0, rf_rd_data1;
    logic                  src_valid;
    logic [LANES*64-1:0]   src_data;
    logic                  dst_req;
    logic [REG_AW-1:0]     dst_idx;
    logic [2:0]            dst_fmt;
    logic [LANES*64-1:0]   dst_data;
    logic                  dst_is_load;
    logic [LANES-1:0]      dst_load_mask, wave_exec;
    logic                  dst_ignore_exec;
    logic [LANES-1:0]      rf_wr_en0, rf_wr_en1;
    logic [REG_AW-1:0]     rf_wr_addr0, rf_wr_addr1;
    logic [LANES*32-1:0]   rf_wr_data0, rf_wr_data1;

    int n_tests = 0;
    int n_fail  = 0;

    vop_xfer #(.LANES(LANES), .REG_AW(REG_AW)) dut (.*);

    // Behavioural register file
    logic [31:0] mem [NREG][LANES];

    function automatic logic [31:0] pat(int r, int l);
        return (r * 32'h9E37_79B1) ^ (l * 32'h7F4A_7C15) ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++)
                for (int l = 0; l < LANES; l++)
                    mem[r][l] <= pat(r, l);
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (rf_wr_en0[l]) mem[rf_wr_addr0][l] <= rf_wr_data0[l*32 +: 32];
                if (rf_wr_en1[l]) mem[rf_wr_addr1][l] <= rf_wr_data1[l*32 +: 32];
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rf_rd_data0[l*32 +: 32] = mem[rf_rd_addr0][l];
            rf_rd_data1[l*32 +: 32] = mem[rf_rd_addr1][l];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_half(logic [2:0] f);  return f == 3'd0 || f == 3'd3; endfunction
    function automatic bit is_wide(logic [2:0] f);  return f == 3'd2 || f == 3'd5; endfunction

    // Model computes expectations from current inputs, then compares after the edge.
    task automatic tick(input string tag);
        logic                 ev;
        logic [LANES*64-1:0]  ed;
        logic [LANES-1:0]     e0, e1;
        logic [LANES*32-1:0]  elo, ehi;
        logic [REG_AW-1:0]    ea0, ea1;
        int                   bad;
        ev = !rst && src_req;
        ed = '0;
        for (int l = 0; l < LANES; l++) begin
            logic [63:0] v;
            int a0, a1, sb;
            a0 = (int'(wave_vbase) + int'(src_sel[7:0])) % NREG;
            a1 = (a0 + 1) % NREG;
            v  = src_sel[8] ? {mem[a1][l], mem[a0][l]} : scalar_val;
            if (is_half(src_fmt))      v = v & 64'hFFFF;
            else if (!is_wide(src_fmt)) v = v & 64'hFFFF_FFFF;
            case (src_fmt)
                3'd3: sb = 15;
                3'd4: sb = 31;
                3'd5: sb = 63;
                default: sb = -1;
            endcase
            if (sb >= 0) begin
                if (src_abs) v[sb] = 1'b0;
                if (src_neg) v[sb] = ~v[sb];
            end
            ed[l*64 +: 64] = v;
        end
        for (int l = 0; l < LANES; l++) begin
            logic [63:0] dv;
            bit m;
            m = dst_is_load ? dst_load_mask[l] : wave_exec[l];
            e0[l] = !rst && dst_req && (dst_ignore_exec || m);
            e1[l] = e0[l] && is_wide(dst_fmt);
            dv = dst_data[l*64 +: 64];
            elo[l*32 +: 32] = is_half(dst_fmt) ? {16'h0, dv[15:0]} : dv[31:0];
            ehi[l*32 +: 32] = dv[63:32];
        end
        ea0 = REG_AW'((int'(wave_vbase) + int'(dst_idx)) % NREG);
        ea1 = REG_AW'((int'(ea0) + 1) % NREG);
        @(posedge clk);
        @(negedge clk);
        chk(src_valid === ev, tag, "src_valid", 64'(src_valid), 64'(ev));
        if (ev) begin
            bad = -1;
            for (int l = 0; l < LANES; l++)
                if (bad < 0 && src_data[l*64 +: 64] !== ed[l*64 +: 64]) bad = l;
            if (bad < 0) chk(1'b1, tag, "src_data", 64'h0, 64'h0);
            else chk(1'b0, tag, $sformatf("src_data lane %0d", bad),
                     src_data[bad*64 +: 64], ed[bad*64 +: 64]);
        end
        chk(rf_wr_en0 === e0, tag, "wr_en0", 64'(rf_wr_en0), 64'(e0));
        chk(rf_wr_en1 === e1, tag, "wr_en1", 64'(rf_wr_en1), 64'(e1));
        if (|e0) begin
            chk(rf_wr_addr0 === ea0, tag, "wr_addr0", 64'(rf_wr_addr0), 64'(ea0));
            bad = -1;
            for (int l = 0; l < LANES; l++)
                if (bad < 0 && e0[l] && rf_wr_data0[l*32 +: 32] !== elo[l*32 +: 32]) bad = l;
            if (bad < 0) chk(1'b1, tag, "wr_data0", 64'h0, 64'h0);
            else chk(1'b0, tag, $sformatf("wr_data0 lane %0d", bad),
                     64'(rf_wr_data0[bad*32 +: 32]), 64'(elo[bad*32 +: 32]));
        end
        if (|e1) begin
            chk(rf_wr_addr1 === ea1, tag, "wr_addr1", 64'(rf_wr_addr1), 64'(ea1));
            bad = -1;
            for (int l = 0; l < LANES; l++)
                if (bad < 0 && e1[l] && rf_wr_data1[l*32 +: 32] !== ehi[l*32 +: 32]) bad = l;
            if (bad < 0) chk(1'b1, tag, "wr_data1", 64'h0, 64'h0);
            else chk(1'b0, tag, $sformatf("wr_data1 lane %0d", bad),
                     64'(rf_wr_data1[bad*32 +: 32]), 64'(ehi[bad*32 +: 32]));
        end
    endtask

    task automatic rd(input logic [8:0] sel, input logic [2:0] f, input logic a,
                      input logic n, input logic [63:0] sc, input string tag);
        src_req = 1'b1; src_sel = sel; src_fmt = f;
        src_abs = a; src_neg = n; scalar_val = sc;
        tick(tag);
        src_req = 1'b0; src_abs = 1'b0; src_neg = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [2:0] f, input logic ld,
                      input logic ign, input logic [63:0] lmask, input logic [63:0] ex,
                      input string tag);
        dst_req = 1'b1; dst_idx = idx; dst_fmt = f; dst_is_load = ld;
        dst_ignore_exec = ign; dst_load_mask = lmask; wave_exec = ex;
        tick(tag);
        dst_req = 1'b0; dst_is_load = 1'b0; dst_ignore_exec = 1'b0;
        tick(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        src_req = 0; src_sel = '0; src_fmt = 3'd1; src_abs = 0; src_neg = 0;
        scalar_val = '0; wave_vbase = '0;
        dst_req = 0; dst_idx = '0; dst_fmt = 3'd1; dst_is_load = 0;
        dst_load_mask = '0; wave_exec = '0; dst_ignore_exec = 0;
        for (int l = 0; l < LANES; l++)
            dst_data[l*64 +: 64] = {32'hC000_0000 | 32'(l), 32'h8000_7F00 ^ (32'(l) * 32'h0101_0101)};

        // R10 reset state, with a request held during reset
        src_req = 1'b1; dst_req = 1'b1; dst_ignore_exec = 1'b1;
        tick("R10");
        tick("R10");
        src_req = 1'b0; dst_req = 1'b0; dst_ignore_exec = 1'b0;
        rst = 1'b0;
        tick("R10");

        // R1 plain 32-bit vector reads, back to back
        rd({1'b1, 8'd10}, 3'd1, 0, 0, 64'h0, "R1");
        rd({1'b1, 8'd11}, 3'd4, 0, 0, 64'h0, "R1");
        tick("R1");
        // R11 base offset and wrap
        wave_vbase = 8'd20;
        rd({1'b1, 8'd10}, 3'd1, 0, 0, 64'h0, "R11");
        wave_vbase = 8'd250;
        rd({1'b1, 8'd10}, 3'd1, 0, 0, 64'h0, "R11");
        rd({1'b1, 8'd5}, 3'd2, 0, 0, 64'h0, "R11");
        wave_vbase = 8'd0;
        // R2 64-bit pair
        rd({1'b1, 8'd30}, 3'd2, 0, 0, 64'h0, "R2");
        rd({1'b1, 8'd31}, 3'd5, 0, 0, 64'h0, "R2");
        // R3 broadcast
        rd({1'b0, 8'd30}, 3'd2, 0, 0, 64'h8123_4567_89AB_CDEF, "R3");
        rd({1'b0, 8'd30}, 3'd1, 0, 0, 64'h8123_4567_89AB_CDEF, "R3");
        // R4 half formats
        rd({1'b1, 8'd12}, 3'd0, 0, 0, 64'h0, "R4");
        rd({1'b1, 8'd13}, 3'd3, 0, 1, 64'h0, "R4");
        rd({1'b0, 8'd0}, 3'd3, 1, 0, 64'hFFFF_FFFF_FFFF_8001, "R4");
        // R5 modifiers and their order
        rd({1'b1, 8'd14}, 3'd4, 1, 1, 64'h0, "R5");
        rd({1'b1, 8'd14}, 3'd4, 0, 1, 64'h0, "R5");
        rd({1'b1, 8'd15}, 3'd5, 1, 0, 64'h0, "R5");
        rd({1'b0, 8'd0}, 3'd5, 1, 1, 64'h7FF0_0000_0000_0001, "R5");
        rd({1'b0, 8'd0}, 3'd4, 1, 1, 64'h0000_0000_8000_0000, "R5");
        // R6 integer formats ignore modifiers
        rd({1'b1, 8'd16}, 3'd1, 1, 1, 64'h0, "R6");
        rd({1'b1, 8'd16}, 3'd2, 1, 1, 64'h0, "R6");
        rd({1'b0, 8'd0}, 3'd0, 1, 1, 64'h0000_0000_0000_8080, "R6");

        // R7 masked write, then readback shows untouched lanes
        wr(8'd40, 3'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_0FF0_1234_5678, "R7");
        rd({1'b1, 8'd40}, 3'd1, 0, 0, 64'h0, "R7");
        wr(8'd41, 3'd1, 0, 1, 64'h0, 64'h0, "R7");
        rd({1'b1, 8'd41}, 3'd1, 0, 0, 64'h0, "R7");
        // R8 load mask replaces exec mask
        wr(8'd42, 3'd4, 1, 0, 64'h0F0F_0000_FFFF_0001, 64'hFFFF_FFFF_0000_0000, "R8");
        rd({1'b1, 8'd42}, 3'd1, 0, 0, 64'h0, "R8");
        wr(8'd43, 3'd1, 1, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        // R9 64-bit split write, readback as pair
        wr(8'd50, 3'd5, 0, 0, 64'h0, 64'h00FF_00FF_FF00_FF00, "R9");
        rd({1'b1, 8'd50}, 3'd2, 0, 0, 64'h0, "R9");
        rd({1'b1, 8'd51}, 3'd1, 0, 0, 64'h0, "R9");
        // R4 half write zero-fills the upper word
        wr(8'd60, 3'd0, 0, 1, 64'h0, 64'h0, "R4");
        rd({1'b1, 8'd60}, 3'd1, 0, 0, 64'h0, "R4");
        // R11 write address wrap across the top of the file
        wave_vbase = 8'd250;
        wr(8'd5, 3'd2, 0, 1, 64'h0, 64'h0, "R11");
        wave_vbase = 8'd0;
        rd({1'b1, 8'd255}, 3'd2, 0, 0, 64'h0, "R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule